// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block holds a small pool of line-sized entries between a core's store port and the next cache level. A store that missed the first-level cache is placed into an entry tagged with its line address. Later stores to the same line are folded into that entry, and a per-byte valid mask records which bytes carry data. When an entry is first allocated, the block asks the downstream level for ownership of the line. The entry drains as one masked line transfer as soon as that ownership is granted, whether or not every byte has been written.

Loads probe the pool before they read the cache. A probe that matches an entry returns the buffered line and its byte mask, so the load can forward the pending bytes. Stores arrive as aligned 8-byte words with byte enables, addressed by word. The probe is combinational and reflects the state registered at the last clock edge.

Top module: `wc_store_buffer`

## Requirements
- R1: After reset every entry is empty: `st_ready` is 1, `dr_valid` is 0, `own_req_valid` is 0, and a probe returns `ld_hit` 0 with `ld_mask` 0.
- R2: A store accepted to a line held by no entry allocates an entry. In the next cycle `own_req_valid` is 1 for one cycle, with `own_req_line` equal to the store's line address. The line address is `st_word_addr` without its low 3 bits.
- R3: A store to a line already held merges into that entry. Word slot s is the low 3 bits of `st_word_addr`, and byte lane b (`st_data[8b+7:8b]`, enabled by `st_be[b]`) lands in line byte 8s+b. Only enabled bytes are overwritten, and their mask bits are ORed in. Line byte k is data bits [8k+7:8k] and mask bit k.
- R4: A probe whose line matches an entry returns `ld_hit` 1 with that entry's data and mask. A probe with no match returns `ld_hit` 0 and `ld_mask` 0.
- R5: An entry is presented on the drain port only after a grant naming its line. A grant that names no held line has no effect.
- R6: While entries wait for ownership, the store port stays ready as long as a free entry exists or the store hits a held line.
- R7: With all 4 entries occupied, a store to a new line sees `st_ready` 0 until an entry drains. In the cycle of that drain handshake, `st_ready` rises and the store takes the freed entry.
- R8: When several granted entries wait behind the one already presented, the entry allocated earliest drains next.
- R9: While `dr_valid` is 1 and `dr_ready` is 0, the presented line stays on the port unchanged in the next cycle.
- R10: A store to a line whose entry completes its drain handshake in the same cycle does not merge. The drained data excludes the store, and the store allocates a fresh entry holding only its own bytes, with a new ownership request.
- R11: The drain handshake frees the entry, so later probes of that line miss.
- R12: A merging store issues no ownership request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_word_addr | input | ADDR_W-3 | Address of the aligned 8-byte word |
| st_data | input | 64 | Store data word |
| st_be | input | 8 | Byte enables for the word |
| ld_line | input | ADDR_W-6 | Line address probed by a load |
| ld_hit | output | 1 | Probe matched an entry |
| ld_data | output | 512 | Buffered line of the matching entry |
| ld_mask | output | 64 | Valid bytes of the matching entry |
| own_req_valid | output | 1 | Ownership request pulse |
| own_req_line | output | ADDR_W-6 | Line whose ownership is requested |
| own_gnt_valid | input | 1 | Ownership grant pulse |
| own_gnt_line | input | ADDR_W-6 | Line whose ownership is granted |
| dr_valid | output | 1 | A granted entry is presented for drain |
| dr_ready | input | 1 | Downstream accepts the drain |
| dr_line | output | ADDR_W-6 | Line address of the drained entry |
| dr_data | output | 512 | Line data of the drained entry |
| dr_mask | output | 64 | Valid byte mask of the drained entry |

## Verification
The bench builds the block with its defaults: a 32-bit byte address, 64-byte lines, 8-byte store words and 4 entries. Four entries make the full condition easy to reach: a fifth distinct line stalls the store port. Grants for the same line can then arrive in an order that differs from allocation order, which puts the oldest-first rule to work. The single-word store width allows exact byte-lane overlap tests inside one line. The narrow pool also lets a store and a drain handshake land on the same line in one cycle.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  localparam int unsigned WCB_ADDR_W     = 32;
  localparam int unsigned WCB_LINE_BYTES = 64;
  localparam int unsigned WCB_WORD_BYTES = 8;
  localparam int unsigned WCB_ENTRIES    = 4;

  // Keep only the lowest set bit of a request vector.
  function automatic logic [31:0] lowest_onehot(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction
endpackage

// File: rtl/wcb_entry.sv
module wcb_entry #(
  parameter int unsigned LINE_W     = 26,
  parameter int unsigned SLOT_W     = 3,
  parameter int unsigned WORD_BYTES = 8,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_i,
  input  logic                      merge_i,
  input  logic                      drain_i,
  input  logic                      gnt_valid_i,
  input  logic [LINE_W-1:0]         gnt_line_i,
  input  logic [LINE_W-1:0]         st_line_i,
  input  logic [SLOT_W-1:0]         st_slot_i,
  input  logic [WORD_BYTES*8-1:0]   st_data_i,
  input  logic [WORD_BYTES-1:0]     st_be_i,
  output logic                      vld_o,
  output logic                      granted_o,
  output logic [LINE_W-1:0]         tag_o,
  output logic [LINE_BYTES*8-1:0]   data_o,
  output logic [LINE_BYTES-1:0]     mask_o
);
  localparam int unsigned LINE_BITS = LINE_BYTES * 8;
  localparam int unsigned WORD_BITS = WORD_BYTES * 8;

  // Byte enables of one word spread to line byte positions.
  function automatic logic [LINE_BYTES-1:0] spread_be(input logic [SLOT_W-1:0] slot,
                                                       input logic [WORD_BYTES-1:0] be);
    return LINE_BYTES'(be) << (slot * WORD_BYTES);
  endfunction

  // Overwrite only the enabled bytes of a line with the shifted word.
  function automatic logic [LINE_BITS-1:0] merge_line(input logic [LINE_BITS-1:0]  old_line,
                                                       input logic [SLOT_W-1:0]     slot,
                                                       input logic [WORD_BITS-1:0]  word,
                                                       input logic [WORD_BYTES-1:0] be);
    logic [LINE_BITS-1:0]  placed;
    logic [LINE_BYTES-1:0] bmask;
    logic [LINE_BITS-1:0]  res;
    placed = LINE_BITS'(word) << (slot * WORD_BITS);
    bmask  = spread_be(slot, be);
    res    = old_line;
    for (int b = 0; b < int'(LINE_BYTES); b++) begin
      if (bmask[b]) res[8*b +: 8] = placed[8*b +: 8];
    end
    return res;
  endfunction

  logic                    vld_q, granted_q;
  logic [LINE_W-1:0]       tag_q;
  logic [LINE_BITS-1:0]    data_q;
  logic [LINE_BYTES-1:0]   mask_q;
  logic                    gnt_match;

  assign gnt_match = vld_q && gnt_valid_i && (gnt_line_i == tag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= 1'b0;
      granted_q <= 1'b0;
      tag_q     <= '0;
      data_q    <= '0;
      mask_q    <= '0;
    end else if (alloc_i) begin
      vld_q     <= 1'b1;
      granted_q <= 1'b0;
      tag_q     <= st_line_i;
      data_q    <= merge_line(data_q, st_slot_i, st_data_i, st_be_i);
      mask_q    <= spread_be(st_slot_i, st_be_i);
    end else if (drain_i) begin
      vld_q     <= 1'b0;
      granted_q <= 1'b0;
      mask_q    <= '0;
    end else begin
      if (merge_i) begin
        data_q <= merge_line(data_q, st_slot_i, st_data_i, st_be_i);
        mask_q <= mask_q | spread_be(st_slot_i, st_be_i);
      end
      if (gnt_match) granted_q <= 1'b1;
    end
  end

  assign vld_o     = vld_q;
  assign granted_o = granted_q;
  assign tag_o     = tag_q;
  assign data_o    = data_q;
  assign mask_o    = mask_q;

  // R11: a drain without reuse leaves the entry empty with a clear mask
  p_free_on_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_i && !alloc_i) |=> (!vld_q && (mask_q == '0)));

  // R5: only a valid entry can hold ownership
  p_grant_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    granted_q |-> vld_q);
endmodule

// File: rtl/wcb_age_arb.sv
module wcb_age_arb #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_i,
  input  logic [N-1:0] cand_i,
  output logic [N-1:0] sel_o
);
  // older_q[i][j] is set when entry i was allocated before entry j.
  logic [N-1:0] older_q [N];
  logic [N-1:0] blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N); i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < int'(N); i++) begin
        for (int j = 0; j < int'(N); j++) begin
          if (i != j) begin
            if (alloc_i[i])      older_q[i][j] <= 1'b0;
            else if (alloc_i[j]) older_q[i][j] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < int'(N); i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < int'(N); j++) begin
        if (j != i && cand_i[j] && older_q[j][i]) blocked[i] = 1'b1;
      end
      sel_o[i] = cand_i[i] && !blocked[i];
    end
  end

  // R8: one winner at most, and a waiting candidate always produces one
  p_one_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));
  p_arb_progress_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_i != '0) |-> (sel_o != '0));
endmodule

// File: rtl/wcb_probe.sv
module wcb_probe #(
  parameter int unsigned N          = 4,
  parameter int unsigned LINE_W     = 26,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic [N-1:0]              vld_i,
  input  logic [LINE_W-1:0]         tag_i  [N],
  input  logic [LINE_BYTES*8-1:0]   data_i [N],
  input  logic [LINE_BYTES-1:0]     mask_i [N],
  input  logic [LINE_W-1:0]         line_i,
  output logic                      hit_o,
  output logic [LINE_BYTES*8-1:0]   data_o,
  output logic [LINE_BYTES-1:0]     mask_o
);
  logic [N-1:0] match;

  always_comb begin
    data_o = '0;
    mask_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      match[i] = vld_i[i] && (tag_i[i] == line_i);
      if (match[i]) begin
        data_o = data_o | data_i[i];
        mask_o = mask_o | mask_i[i];
      end
    end
    hit_o = |match;
  end
endmodule

// File: rtl/wc_store_buffer.sv
module wc_store_buffer #(
  parameter int unsigned ADDR_W     = wcb_pkg::WCB_ADDR_W,
  parameter int unsigned LINE_BYTES = wcb_pkg::WCB_LINE_BYTES,
  parameter int unsigned WORD_BYTES = wcb_pkg::WCB_WORD_BYTES,
  parameter int unsigned ENTRIES    = wcb_pkg::WCB_ENTRIES
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     st_valid,
  output logic                                     st_ready,
  input  logic [ADDR_W-$clog2(WORD_BYTES)-1:0]     st_word_addr,
  input  logic [WORD_BYTES*8-1:0]                  st_data,
  input  logic [WORD_BYTES-1:0]                    st_be,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]     ld_line,
  output logic                                     ld_hit,
  output logic [LINE_BYTES*8-1:0]                  ld_data,
  output logic [LINE_BYTES-1:0]                    ld_mask,
  output logic                                     own_req_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]     own_req_line,
  input  logic                                     own_gnt_valid,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]     own_gnt_line,
  output logic                                     dr_valid,
  input  logic                                     dr_ready,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]     dr_line,
  output logic [LINE_BYTES*8-1:0]                  dr_data,
  output logic [LINE_BYTES-1:0]                    dr_mask
);
  localparam int unsigned OFS_W     = $clog2(LINE_BYTES);
  localparam int unsigned LO_W      = $clog2(WORD_BYTES);
  localparam int unsigned SLOT_W    = OFS_W - LO_W;
  localparam int unsigned LINE_W    = ADDR_W - OFS_W;
  localparam int unsigned LINE_BITS = LINE_BYTES * 8;

  logic [LINE_W-1:0]     st_line;
  logic [SLOT_W-1:0]     st_slot;

  logic [ENTRIES-1:0]    vld, granted;
  logic [LINE_W-1:0]     tag  [ENTRIES];
  logic [LINE_BITS-1:0]  data [ENTRIES];
  logic [LINE_BYTES-1:0] mask [ENTRIES];

  // Named internal events, used by the assertions.
  logic [ENTRIES-1:0]    held_match;   // valid entries whose tag equals the store line
  logic [ENTRIES-1:0]    st_hit_vec;   // merge targets (exclude entries draining now)
  logic [ENTRIES-1:0]    free_vec;     // entries that can take a new line this cycle
  logic [ENTRIES-1:0]    alloc_vec;
  logic [ENTRIES-1:0]    merge_vec;
  logic [ENTRIES-1:0]    arb_sel, dr_sel, drain_fire;
  logic [ENTRIES-1:0]    lock_vec;
  logic                  lock_q;
  logic                  st_hit, st_fire, dr_fire;

  assign st_line = st_word_addr[LINE_W+SLOT_W-1:SLOT_W];
  assign st_slot = st_word_addr[SLOT_W-1:0];

  // Drain selection: a stalled presentation is locked in place.
  wcb_age_arb #(.N(ENTRIES)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .alloc_i(alloc_vec),
    .cand_i (vld & granted),
    .sel_o  (arb_sel)
  );

  assign dr_sel     = lock_q ? lock_vec : arb_sel;
  assign dr_valid   = |dr_sel;
  assign dr_fire    = dr_valid && dr_ready;
  assign drain_fire = dr_ready ? dr_sel : '0;

  always_comb begin
    dr_line = '0;
    dr_data = '0;
    dr_mask = '0;
    for (int i = 0; i < int'(ENTRIES); i++) begin
      if (dr_sel[i]) begin
        dr_line = dr_line | tag[i];
        dr_data = dr_data | data[i];
        dr_mask = dr_mask | mask[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      lock_vec <= '0;
    end else begin
      lock_q   <= dr_valid && !dr_ready;
      lock_vec <= dr_sel;
    end
  end

  // Store side: merge, or allocate a free (or just-drained) entry.
  always_comb begin
    for (int i = 0; i < int'(ENTRIES); i++) begin
      held_match[i] = vld[i] && (tag[i] == st_line);
      st_hit_vec[i] = held_match[i] && !drain_fire[i];
    end
  end

  assign free_vec  = ~vld | drain_fire;
  assign st_hit    = |st_hit_vec;
  assign st_ready  = st_hit || (|free_vec);
  assign st_fire   = st_valid && st_ready;
  assign alloc_vec = (st_fire && !st_hit)
                   ? ENTRIES'(wcb_pkg::lowest_onehot(32'(free_vec))) : '0;
  assign merge_vec = st_fire ? st_hit_vec : '0;

  for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_entry
    wcb_entry #(
      .LINE_W    (LINE_W),
      .SLOT_W    (SLOT_W),
      .WORD_BYTES(WORD_BYTES),
      .LINE_BYTES(LINE_BYTES)
    ) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (alloc_vec[g]),
      .merge_i    (merge_vec[g]),
      .drain_i    (drain_fire[g]),
      .gnt_valid_i(own_gnt_valid),
      .gnt_line_i (own_gnt_line),
      .st_line_i  (st_line),
      .st_slot_i  (st_slot),
      .st_data_i  (st_data),
      .st_be_i    (st_be),
      .vld_o      (vld[g]),
      .granted_o  (granted[g]),
      .tag_o      (tag[g]),
      .data_o     (data[g]),
      .mask_o     (mask[g])
    );
  end

  // Ownership request, one cycle after allocation.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_req_valid <= 1'b0;
      own_req_line  <= '0;
    end else begin
      own_req_valid <= |alloc_vec;
      if (|alloc_vec) own_req_line <= st_line;
    end
  end

  // Load probe.
  wcb_probe #(.N(ENTRIES), .LINE_W(LINE_W), .LINE_BYTES(LINE_BYTES)) u_probe (
    .vld_i (vld),
    .tag_i (tag),
    .data_i(data),
    .mask_i(mask),
    .line_i(ld_line),
    .hit_o (ld_hit),
    .data_o(ld_data),
    .mask_o(ld_mask)
  );

  // R3: a line is held by one entry at most
  p_line_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(held_match));

  // R7: full pool with no hit and no drain handshake refuses stores
  p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((&vld) && !st_hit && !dr_fire) |-> !st_ready);

  // R2: allocation is followed by a request for that line
  p_req_after_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|alloc_vec) |=> (own_req_valid && (own_req_line == $past(st_line))));

  // R12: a merge raises no request
  p_merge_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fire && st_hit) |=> !own_req_valid);

  // R9: a stalled drain keeps its line on the port
  p_drain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_line)));

  // R10: no entry is merged in the cycle it drains
  p_no_merge_into_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_vec & drain_fire) == '0);

  // R5: the presented entry holds ownership
  p_drain_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid |-> ((dr_sel & vld & granted) != '0));
endmodule

// File: tb/test_wc_store_buffer.sv
module test_wc_store_buffer;
  localparam int LW = 26;
  localparam int WW = 29;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           st_valid = 1'b0;
  logic           st_ready;
  logic [WW-1:0]  st_word_addr = '0;
  logic [63:0]    st_data = '0;
  logic [7:0]     st_be = '0;
  logic [LW-1:0]  ld_line = '0;
  logic           ld_hit;
  logic [511:0]   ld_data;
  logic [63:0]    ld_mask;
  logic           own_req_valid;
  logic [LW-1:0]  own_req_line;
  logic           own_gnt_valid = 1'b0;
  logic [LW-1:0]  own_gnt_line = '0;
  logic           dr_valid;
  logic           dr_ready = 1'b0;
  logic [LW-1:0]  dr_line;
  logic [511:0]   dr_data;
  logic [63:0]    dr_mask;

  int checks = 0;
  int fails  = 0;
  logic           req_seen;
  logic [LW-1:0]  req_line_seen;
  logic [LW-1:0]  got_line;
  logic [511:0]   got_data;
  logic [63:0]    got_mask;

  always #5 clk = ~clk;

  wc_store_buffer i_wc_store_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_word_addr(st_word_addr),
    .st_data(st_data), .st_be(st_be),
    .ld_line(ld_line), .ld_hit(ld_hit), .ld_data(ld_data), .ld_mask(ld_mask),
    .own_req_valid(own_req_valid), .own_req_line(own_req_line),
    .own_gnt_valid(own_gnt_valid), .own_gnt_line(own_gnt_line),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_line(dr_line),
    .dr_data(dr_data), .dr_mask(dr_mask)
  );

  task automatic check(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench-side model of line placement: one byte at a time.
  function automatic logic [63:0] mask_of(input logic [2:0] slot, input logic [7:0] be);
    logic [63:0] m = '0;
    for (int b = 0; b < 8; b++) if (be[b]) m[int'(slot)*8 + b] = 1'b1;
    return m;
  endfunction

  function automatic logic [511:0] put(input logic [511:0] img, input logic [2:0] slot,
                                       input logic [63:0] d, input logic [7:0] be);
    logic [511:0] r = img;
    for (int b = 0; b < 8; b++)
      if (be[b]) r[(int'(slot)*8 + b)*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [511:0] bits_of(input logic [63:0] m);
    logic [511:0] r = '0;
    for (int k = 0; k < 64; k++) if (m[k]) r[k*8 +: 8] = 8'hFF;
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; st_valid = 1'b0; own_gnt_valid = 1'b0; dr_ready = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
  endtask

  task automatic do_store(input logic [LW-1:0] line, input logic [2:0] slot,
                          input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    st_valid = 1'b1; st_word_addr = {line, slot}; st_data = d; st_be = be;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    st_valid = 1'b0;
    req_seen = own_req_valid; req_line_seen = own_req_line;
  endtask

  task automatic do_grant(input logic [LW-1:0] line);
    @(negedge clk); own_gnt_valid = 1'b1; own_gnt_line = line;
    @(posedge clk); #1; own_gnt_valid = 1'b0;
  endtask

  task automatic do_accept();
    @(negedge clk); dr_ready = 1'b1; #1;
    got_line = dr_line; got_data = dr_data; got_mask = dr_mask;
    @(posedge clk); #1; dr_ready = 1'b0;
  endtask

  task automatic probe(input logic [LW-1:0] line);
    ld_line = line; #1;
  endtask

  task automatic t_reset();
    do_reset();
    probe(26'h0);
    check(st_ready == 1'b1, "R1 st_ready", 512'(st_ready), 512'd1);
    check(dr_valid == 1'b0 && own_req_valid == 1'b0, "R1 dr/req idle",
          512'({dr_valid, own_req_valid}), 512'd0);
    check(ld_hit == 1'b0 && ld_mask == 64'd0, "R1 probe empty", 512'(ld_mask), 512'd0);
  endtask

  task automatic t_merge();
    logic [511:0] img = '0;
    logic [63:0]  m = '0;
    logic [LW-1:0] a = 26'h0012345;
    do_reset();
    do_store(a, 3'd1, 64'h1111_2222_3333_4444, 8'h0F);
    img = put(img, 3'd1, 64'h1111_2222_3333_4444, 8'h0F); m |= mask_of(3'd1, 8'h0F);
    check(req_seen && req_line_seen == a, "R2 ownership request", 512'(req_line_seen), 512'(a));
    do_store(a, 3'd6, 64'hA5A5_5A5A_0102_0304, 8'hFF);
    img = put(img, 3'd6, 64'hA5A5_5A5A_0102_0304, 8'hFF); m |= mask_of(3'd6, 8'hFF);
    check(!req_seen, "R12 merge without request", 512'(req_seen), 512'd0);
    do_store(a, 3'd1, 64'hFFFF_FFFF_FFFF_BEEF, 8'h03);
    img = put(img, 3'd1, 64'hFFFF_FFFF_FFFF_BEEF, 8'h03); m |= mask_of(3'd1, 8'h03);
    probe(a);
    check(ld_hit && ld_mask == m, "R3 merged mask", 512'(ld_mask), 512'(m));
    check((ld_data & bits_of(m)) == img, "R3 merged bytes", ld_data & bits_of(m), img);
    check(ld_hit, "R4 probe hit", 512'(ld_hit), 512'd1);
    probe(a + 26'd1);
    check(!ld_hit && ld_mask == 64'd0, "R4 probe miss", 512'(ld_mask), 512'd0);
    // R6: store port stays open while this line awaits ownership
    @(negedge clk); st_valid = 1'b1; st_word_addr = {a + 26'd7, 3'd0}; st_be = 8'h01; #1;
    check(st_ready == 1'b1, "R6 ready while waiting", 512'(st_ready), 512'd1);
    @(posedge clk); #1; st_valid = 1'b0;
  endtask

  task automatic t_drain();
    logic [LW-1:0] a = 26'h0000777;
    logic [511:0] img;
    do_reset();
    do_store(a, 3'd7, 64'hCAFE_F00D_1234_5678, 8'hF0);
    img = put('0, 3'd7, 64'hCAFE_F00D_1234_5678, 8'hF0);
    do_grant(a + 26'd3);
    check(!dr_valid, "R5 unrelated grant ignored", 512'(dr_valid), 512'd0);
    do_grant(a);
    check(dr_valid && dr_line == a, "R5 drain after grant", 512'(dr_line), 512'(a));
    @(negedge clk); #1;
    check(dr_valid && dr_line == a, "R9 held while stalled", 512'(dr_line), 512'(a));
    do_accept();
    check(got_mask == mask_of(3'd7, 8'hF0), "R3 drain mask", 512'(got_mask),
          512'(mask_of(3'd7, 8'hF0)));
    check((got_data & bits_of(got_mask)) == img, "R3 drain data",
          got_data & bits_of(got_mask), img);
    probe(a);
    check(!ld_hit && !dr_valid, "R11 entry freed", 512'({ld_hit, dr_valid}), 512'd0);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 4; i++) do_store(26'h100 + 26'(i), 3'd0, 64'(i), 8'h01);
    @(negedge clk); st_valid = 1'b1; st_word_addr = {26'h200, 3'd2};
    st_data = 64'h55; st_be = 8'h01; #1;
    check(!st_ready, "R7 stall when full", 512'(st_ready), 512'd0);
    @(negedge clk); own_gnt_valid = 1'b1; own_gnt_line = 26'h101; #1;
    check(!st_ready, "R7 stall persists", 512'(st_ready), 512'd0);
    @(posedge clk); #1; own_gnt_valid = 1'b0;
    check(dr_valid && !st_ready, "R7 stall until handshake", 512'(st_ready), 512'd0);
    @(negedge clk); dr_ready = 1'b1; #1;
    check(st_ready && dr_line == 26'h101, "R7 ready on drain", 512'(st_ready), 512'd1);
    @(posedge clk); #1; dr_ready = 1'b0; st_valid = 1'b0;
    check(own_req_valid && own_req_line == 26'h200, "R7 store took freed entry",
          512'(own_req_line), 512'h200);
  endtask

  task automatic t_order();
    do_reset();
    do_store(26'h300, 3'd0, 64'h1, 8'h01);
    do_store(26'h301, 3'd0, 64'h2, 8'h01);
    do_store(26'h302, 3'd0, 64'h3, 8'h01);
    do_grant(26'h302);
    do_grant(26'h301);
    do_grant(26'h300);
    do_accept();
    check(got_line == 26'h302, "R9 locked presentation first", 512'(got_line), 512'h302);
    check(dr_valid && dr_line == 26'h300, "R8 oldest next", 512'(dr_line), 512'h300);
    do_accept();
    check(dr_valid && dr_line == 26'h301, "R8 younger last", 512'(dr_line), 512'h301);
    do_accept();
  endtask

  task automatic t_collide();
    logic [LW-1:0] a = 26'h0000ABC;
    do_reset();
    do_store(a, 3'd0, 64'h0102_0304_0506_0708, 8'hFF);
    do_grant(a);
    @(negedge clk);
    dr_ready = 1'b1; st_valid = 1'b1; st_word_addr = {a, 3'd0};
    st_data = 64'hEEEE_EEEE_9999_8888; st_be = 8'h0F; #1;
    got_data = dr_data; got_mask = dr_mask;
    check(st_ready, "R10 store accepted", 512'(st_ready), 512'd1);
    @(posedge clk); #1; dr_ready = 1'b0; st_valid = 1'b0;
    check(got_data[63:0] == 64'h0102_0304_0506_0708 && got_mask == 64'hFF,
          "R10 drained data excludes store", 512'(got_data[63:0]), 512'h0102030405060708);
    check(own_req_valid && own_req_line == a, "R10 fresh request", 512'(own_req_line), 512'(a));
    probe(a);
    check(ld_hit && ld_mask == 64'h0F, "R10 fresh mask", 512'(ld_mask), 512'h0F);
    check(ld_data[31:0] == 32'h9999_8888, "R10 fresh bytes", 512'(ld_data[31:0]), 512'h99998888);
  endtask

  initial begin
    t_reset();
    t_merge();
    t_drain();
    t_full();
    t_order();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule